// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Qualifier

This block watches the asynchronous control and data pins of a byte-wide parallel flash bus and decides, using a fast internal clock, when a genuine write cycle has taken place. Chip enable, write enable and output enable are all active low. Every pin passes through a synchronizer. The three control pins then pass through a glitch filter whose width is a parameter counted in internal clocks. The qualifier latches the address at the later of the two enable falling edges. It latches the data at the earlier of the two enable rising edges. At that rising edge it hands the command logic a one-cycle strobe together with the latched address and data.

Writes are locked out in three situations: while output enable is low, while the digital low-supply flag is raised, and after reset or a supply dip when the bus was already parked in the write state. While the supply flag is raised, the block also asks the command logic to return to read mode.

Top module: `flash_write_qualifier`

## Requirements
- R1: The reported address is the address bus value at the later of the two enable falling edges; address changes before that edge or after it, while both enables stay low, do not affect it.
- R2: The reported data is the data bus value at the earlier of the two enable rising edges; data driven after that edge is not taken.
- R3: Each accepted write gives exactly one strobe cycle. The strobe is high in the clock cycle after posedge number SYNC_STAGES+FILT_CYC+1, counted from the first rising enable edge.
- R4: `wr_addr_o` and `wr_data_o` reset to zero and change only in the cycle in which the strobe is high.
- R5: Output enable low stops any write. This holds when output enable is low before the enables fall, and also when it goes low after a cycle has started (the cycle is dropped). After an abort, both enables must not be low at the same time again before a new cycle can start.
- R6: A control pin level lasting fewer than FILT_CYC clocks is ignored; a level lasting FILT_CYC clocks or more is taken. This applies both to short low pulses that would start a write and to short high pulses inside a write.
- R7: While the low-supply flag is high, no write is accepted, `cmd_reset_o` is high two clocks after the flag rises, and a cycle that was in progress is dropped. After the flag falls, chip enable or write enable must go high before any new cycle can start.
- R8: If chip enable and write enable are both low with output enable high when reset is released, the next rising enable edge produces no strobe; the write that follows is accepted.
- R9: During and right after reset, `wr_strobe_o`, `cmd_reset_o`, `wr_addr_o` and `wr_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset; re-arms the power-up lockout |
| ce_ni | input | 1 | Chip enable pin, active low |
| we_ni | input | 1 | Write enable pin, active low |
| oe_ni | input | 1 | Output enable pin, active low |
| addr_i | input | ADDR_W | Address pins |
| data_i | input | DATA_W | Data pins |
| lowv_i | input | 1 | Low-supply flag, active high |
| wr_strobe_o | output | 1 | One-cycle pulse per accepted write |
| wr_addr_o | output | ADDR_W | Address of the last accepted write |
| wr_data_o | output | DATA_W | Data of the last accepted write |
| cmd_reset_o | output | 1 | Request to return the command logic to read mode |

## Verification
The bench tries all four fall/rise orderings of chip enable and write enable. It moves the address between the two falls and flips the data on the first rise. A design that latched on the wrong edge would report the junk or the flipped value. It sweeps low-pulse widths across the filter threshold and high-pulse widths inside a write: an off-by-one filter would accept a pulse one clock too short or drop one at the exact limit. Output enable aborts, a supply dip in mid-cycle and a reset taken with the bus parked low are all driven. A lockout that re-armed too early would emit a strobe on the enable rise that follows.

// File: rtl/flash_wq_pkg.sv
package flash_wq_pkg;
  // bit order of the synchronized control bundle
  localparam int CTL_OE = 0;
  localparam int CTL_WE = 1;
  localparam int CTL_CE = 2;
  localparam int CTL_W  = 3;

  typedef enum logic [1:0] {
    ST_LOCK   = 2'd0,
    ST_IDLE   = 2'd1,
    ST_ACTIVE = 2'd2
  } wq_state_e;
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wq_deglitch.sv
module wq_deglitch #(
  parameter int   FILT_CYC = 4,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CNT_W = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             q_q;

  // new level must persist FILT_CYC samples before it is passed on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= RST_VAL;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      q_q   <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/wq_ctrl.sv
module wq_ctrl
  import flash_wq_pkg::*;
#(
  parameter int SETTLE_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] ctl_f_i,
  input  logic             lowv_i,
  output logic             fire_o
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC);

  wq_state_e        st_q, st_d;
  logic [SET_W-1:0] set_q;
  logic             settled;
  logic             ce_f, we_f, oe_f;
  logic             bus_idle, bus_write;

  assign ce_f      = ctl_f_i[CTL_CE];
  assign we_f      = ctl_f_i[CTL_WE];
  assign oe_f      = ctl_f_i[CTL_OE];
  assign bus_idle  = ce_f | we_f;
  assign bus_write = ~ce_f & ~we_f & oe_f;
  assign settled   = (set_q == SET_LAST);

  // wait for the filter pipeline to show real pin levels after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       set_q <= '0;
    else if (!settled) set_q <= set_q + 1'b1;
  end

  always_comb begin
    st_d   = st_q;
    fire_o = 1'b0;
    if (lowv_i) begin
      st_d = ST_LOCK;
    end else begin
      unique case (st_q)
        ST_LOCK:   if (settled && bus_idle) st_d = ST_IDLE;
        ST_IDLE:   if (bus_write) st_d = ST_ACTIVE;
        ST_ACTIVE: begin
          if (!oe_f) begin
            st_d = ST_LOCK;
          end else if (bus_idle) begin
            fire_o = 1'b1;
            st_d   = ST_IDLE;
          end
        end
        default:   st_d = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_LOCK;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/wq_capture.sv
module wq_capture #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_s_i,
  input  logic [ADDR_W-1:0] addr_s_i,
  input  logic [DATA_W-1:0] data_s_i,
  input  logic              fire_i,
  output logic              strobe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              act_q;
  logic [ADDR_W-1:0] addr_sh_q, addr_q;
  logic [DATA_W-1:0] data_sh_q, data_q;
  logic              strobe_q;

  // shadows run on the unfiltered synchronized bus, aligned with the pin edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      addr_sh_q <= '0;
      data_sh_q <= '0;
    end else begin
      act_q <= act_s_i;
      if (act_s_i && !act_q) addr_sh_q <= addr_s_i;
      if (act_s_i)           data_sh_q <= data_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      strobe_q <= fire_i;
      if (fire_i) begin
        addr_q <= addr_sh_q;
        data_q <= data_sh_q;
      end
    end
  end

  assign strobe_o = strobe_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
endmodule

// File: rtl/flash_write_qualifier.sv
module flash_write_qualifier
  import flash_wq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              lowv_i,
  output logic              wr_strobe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              cmd_reset_o
);
  localparam int SETTLE_CYC = SYNC_STAGES + FILT_CYC + 2;

  logic [CTL_W-1:0]  ctl_raw, ctl_s, ctl_f;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              lowv_s;
  logic              act_s;
  logic              fire;

  always_comb begin
    ctl_raw         = '0;
    ctl_raw[CTL_CE] = ce_ni;
    ctl_raw[CTL_WE] = we_ni;
    ctl_raw[CTL_OE] = oe_ni;
  end

  wq_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ctl_raw), .q_o(ctl_s)
  );
  wq_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(addr_i), .q_o(addr_s)
  );
  wq_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(data_i), .q_o(data_s)
  );
  wq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_lowv (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lowv_i), .q_o(lowv_s)
  );

  for (genvar g = 0; g < CTL_W; g++) begin : g_filt
    wq_deglitch #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ctl_s[g]), .q_o(ctl_f[g])
    );
  end

  assign act_s = ~ctl_s[CTL_CE] & ~ctl_s[CTL_WE] & ctl_s[CTL_OE];

  wq_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_f_i(ctl_f), .lowv_i(lowv_s), .fire_o(fire)
  );

  wq_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_s_i(act_s), .addr_s_i(addr_s),
    .data_s_i(data_s), .fire_i(fire), .strobe_o(wr_strobe_o),
    .addr_o(wr_addr_o), .data_o(wr_data_o)
  );

  assign cmd_reset_o = lowv_s;
endmodule

// File: rtl/flash_wq_checker.sv
module flash_wq_checker #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_strobe_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              cmd_reset_o,
  input logic              oe_f
);
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |=> !wr_strobe_o); // R3

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_strobe_o |-> ($stable(wr_addr_o) && $stable(wr_data_o))); // R4

  AST_OE_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_f |=> !wr_strobe_o); // R5

  AST_LOWV_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_reset_o |=> !wr_strobe_o); // R7

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!wr_strobe_o && !cmd_reset_o); // R9
    end
  end
endmodule

bind flash_write_qualifier flash_wq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_strobe_o(wr_strobe_o), .wr_addr_o(wr_addr_o),
  .wr_data_o(wr_data_o), .cmd_reset_o(cmd_reset_o),
  .oe_f(ctl_f[flash_wq_pkg::CTL_OE])
);

// File: tb/flash_write_qualifier_test.sv
`timescale 1ns/1ps
module flash_write_qualifier_test;
  localparam int AW   = 18;
  localparam int DW   = 8;
  localparam int SYNC = 2;
  localparam int FILT = 4;
  localparam int LAT  = SYNC + FILT + 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1, lowv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic          wr_strobe_o, cmd_reset_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;

  int            checks = 0, errors = 0, strobes = 0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  bit            done = 1'b0;

  flash_write_qualifier #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNC), .FILT_CYC(FILT)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .addr_i(addr_i), .data_i(data_i), .lowv_i(lowv_i), .wr_strobe_o(wr_strobe_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .cmd_reset_o(cmd_reset_o)
  );

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (wr_strobe_o) begin
      strobes   <= strobes + 1;
      last_addr <= wr_addr_o;
      last_data <= wr_data_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // one write: ce_first picks which enable falls first, ce_rise_first which rises first
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit ce_first, input bit ce_rise_first);
    int base;
    oe_ni = 1'b1; addr_i = a ^ 18'h2A5A5; data_i = ~d;
    step(1);
    if (ce_first) ce_ni = 1'b0; else we_ni = 1'b0;
    step(3);
    if (ce_first) we_ni = 1'b0; else ce_ni = 1'b0;
    addr_i = a; data_i = d;
    step(FILT + 8);
    addr_i = ~a; // R1: changes after the later fall are ignored
    step(4);
    base = strobes;
    if (ce_rise_first) ce_ni = 1'b1; else we_ni = 1'b1;
    data_i = ~d; // R2: data after the first rise is ignored
    for (int k = 1; k <= LAT + 3; k++) begin
      @(posedge clk_i); #2;
      chk("R3 strobe timing", 32'(wr_strobe_o), 32'(k == LAT));
    end
    @(negedge clk_i);
    if (ce_rise_first) we_ni = 1'b1; else ce_ni = 1'b1;
    step(FILT + 8);
    chk("R3 one strobe", 32'(strobes), 32'(base + 1));
    chk("R1 address", 32'(last_addr), 32'(a));
    chk("R2 data", 32'(last_data), 32'(d));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held_a;
    logic [DW-1:0] held_d;
    int base;
    // R9 reset state
    step(3);
    chk("R9 strobe", 32'(wr_strobe_o), 0);
    chk("R9 addr", 32'(wr_addr_o), 0);
    chk("R9 data", 32'(wr_data_o), 0);
    chk("R9 cmd_reset", 32'(cmd_reset_o), 0);
    rst_ni = 1'b1;
    step(2);
    chk("R9 after release", 32'({wr_strobe_o, cmd_reset_o, wr_addr_o, wr_data_o}), 0);
    step(FILT + 6);

    // R1 R2 R3: all edge orderings, several patterns
    for (int p = 0; p < 8; p++)
      do_write(AW'(p * 32'h0F0F1 + 17), DW'(p * 37 + 5), p[0], p[1]);
    for (int b = 0; b < AW; b++)
      do_write(AW'(1) << b, DW'(8'h80 >> (b % DW)), b[0], b[1]);
    do_write('1, 8'hFF, 1'b1, 1'b1);
    do_write('0, 8'h00, 1'b0, 1'b0);

    // R6 low pulse sweep on write enable
    for (int w = 1; w <= FILT + 2; w++) begin
      held_a = wr_addr_o; held_d = wr_data_o;
      addr_i = AW'(w * 333); data_i = DW'(w + 100);
      ce_ni = 1'b0; step(2);
      base = strobes;
      we_ni = 1'b0; step(w); we_ni = 1'b1;
      step(FILT + 10);
      ce_ni = 1'b1; step(FILT + 6);
      chk("R6 low pulse", 32'(strobes - base), 32'(w >= FILT));
      if (w < FILT)
        chk("R4 hold after glitch", 32'({wr_addr_o, wr_data_o}), 32'({held_a, held_d}));
      else
        chk("R6 taken addr", 32'(wr_addr_o), 32'(AW'(w * 333)));
    end

    // R6 short high pulse inside a write
    for (int w = 1; w < FILT; w++) begin
      addr_i = AW'(w + 7); data_i = DW'(w + 50);
      base = strobes;
      ce_ni = 1'b0; we_ni = 1'b0; step(FILT + 6);
      we_ni = 1'b1; step(w); we_ni = 1'b0;
      step(FILT + 6);
      we_ni = 1'b1; step(FILT + 6); ce_ni = 1'b1; step(FILT + 6);
      chk("R6 high glitch", 32'(strobes - base), 1);
    end

    // R5 output enable low before and during a cycle
    held_a = wr_addr_o; held_d = wr_data_o;
    base = strobes;
    oe_ni = 1'b0; addr_i = 18'h12345; data_i = 8'h3C;
    ce_ni = 1'b0; we_ni = 1'b0; step(FILT + 8);
    we_ni = 1'b1; step(FILT + 8); ce_ni = 1'b1; oe_ni = 1'b1; step(FILT + 6);
    chk("R5 oe low at start", 32'(strobes - base), 0);
    ce_ni = 1'b0; we_ni = 1'b0; step(FILT + 8);
    oe_ni = 1'b0; step(FILT + 4);
    oe_ni = 1'b1; step(FILT + 4);
    we_ni = 1'b1; step(FILT + 8); ce_ni = 1'b1; step(FILT + 6);
    chk("R5 oe abort", 32'(strobes - base), 0);
    chk("R4 hold after abort", 32'({wr_addr_o, wr_data_o}), 32'({held_a, held_d}));
    do_write(18'h0ABCD, 8'h5A, 1'b1, 1'b0);

    // R7 low-supply flag
    @(negedge clk_i); lowv_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i); #2;
    chk("R7 cmd_reset rise", 32'(cmd_reset_o), 1);
    base = strobes;
    ce_ni = 1'b0; we_ni = 1'b0; step(FILT + 8);
    we_ni = 1'b1; step(FILT + 8); ce_ni = 1'b1; step(FILT + 6);
    chk("R7 write blocked", 32'(strobes - base), 0);
    lowv_i = 1'b0; step(4);
    chk("R7 cmd_reset fall", 32'(cmd_reset_o), 0);
    ce_ni = 1'b0; we_ni = 1'b0; step(FILT + 8);
    lowv_i = 1'b1; step(6); lowv_i = 1'b0; step(FILT + 8);
    we_ni = 1'b1; step(FILT + 8); ce_ni = 1'b1; step(FILT + 6);
    chk("R7 mid-cycle dip", 32'(strobes - base), 0);
    do_write(18'h3C3C3, 8'hA5, 1'b0, 1'b1);

    // R8 reset taken with the bus parked in the write state
    @(negedge clk_i);
    rst_ni = 1'b0; oe_ni = 1'b1; ce_ni = 1'b0; we_ni = 1'b0;
    step(3);
    rst_ni = 1'b1;
    base = strobes;
    step(30);
    we_ni = 1'b1; step(FILT + 8); ce_ni = 1'b1; step(FILT + 6);
    chk("R8 parked rise ignored", 32'(strobes - base), 0);
    do_write(18'h2468A, 8'hC3, 1'b1, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule